// File: doc/BRIEF.md
# Power-On and System Reset Sequencer

This block controls reset for a small 8-bit microcontroller. A power-on pulse resets it at once. After that it runs a counted sequence in phases. First the module clocks stay gated while the oscillator settles. Then the block pulls the shared open-drain reset pin low for a fixed time. A final quiet tail keeps the core in reset before the CPU is released.

Four internal requests can also restart the sequence: low-voltage detect, watchdog expiry, illegal opcode and illegal address. An outside device that pulls the reset pin low does the same. These restarts skip the stabilization phase.

A six-bit status register keeps the cause of the most recent reset. Software reads it, and a read clears it. All request inputs and the sensed pin level pass through a two-flop synchronizer. The block ignores the sensed pin while it drives the pin itself, because it would otherwise see its own pulse as an outside reset.

Top module: `reset_sequencer`

## Requirements
- R1: While `por` is high, the outputs are forced without waiting for a clock edge: `int_rst`=1, `clk_en`=0, `pin_pull_low`=1, `cpu_run`=0, `status`=6'b000001.
- R2: After `por` falls, `clk_en` stays low for 4096 clock cycles and then goes high.
- R3: After `por` falls, `pin_pull_low` stays high for 4096+32 = 4128 cycles.
- R4: After `por` falls, `int_rst` stays high for 4160 cycles, which is 32 cycles past the end of the pin drive. `cpu_run` goes high in the same cycle that `int_rst` falls. At that point `clk_en` is 1 and `pin_pull_low` is 0.
- R5: Each bit of `status` records one cause: bit0 power-on, bit1 low voltage, bit2 watchdog, bit3 illegal opcode, bit4 illegal address, bit5 external pin. At most one bit is ever set. A new reset sets only the bit of its own cause.
- R6: A one-cycle internal request (low voltage, watchdog, illegal opcode or illegal address) leads to 32 cycles of `pin_pull_low` and 64 cycles of `int_rst` in total. `clk_en` stays high throughout.
- R7: An outside device holding the pin low for N cycles leads to N+31 cycles of `int_rst` and no pin drive by the block. The tail phase restarts each cycle the synchronized pin is seen low.
- R8: The sensed pin is ignored while `pin_pull_low` is high and for 2 cycles after it falls, so a low level in that window neither restarts the sequence nor changes `status`.
- R9: A request that arrives during the drive or tail phase restarts the drive phase, and its cause replaces `status`. Two requests k cycles apart give k+64 cycles of `int_rst`.
- R10: When requests arrive together, the highest priority one is recorded. The order from highest is low voltage, watchdog, illegal opcode, illegal address, external pin.
- R11: Requests that arrive during the 4096-cycle stabilization phase are ignored. The power-on timing and `status`=6'b000001 are left unchanged.
- R12: A one-cycle `status_rd` pulse clears `status` to zero in the next cycle, unless a new reset cause is captured at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that the sequence counts |
| por | input | 1 | Power-on pulse, active high, asynchronous |
| lvd_req | input | 1 | Low-voltage reset request (asynchronous level) |
| wdt_req | input | 1 | Watchdog reset request (asynchronous level) |
| bad_op_req | input | 1 | Illegal-opcode reset request |
| bad_addr_req | input | 1 | Illegal-address reset request |
| pin_sense_n | input | 1 | Sensed level of the open-drain reset pin, low = reset |
| status_rd | input | 1 | Read strobe for the status register; the read clears it |
| pin_pull_low | output | 1 | 1 = pull the reset pin low |
| int_rst | output | 1 | Internal reset to the core and modules |
| clk_en | output | 1 | Module clock enable, low while the oscillator settles |
| cpu_run | output | 1 | CPU released from reset |
| status | output | 6 | Cause of the last reset, one-hot or zero |

## Verification
The hardest cases to reach from the ports involve the pin: the block's own pull shows up on `pin_sense_n`, and a request arriving during stabilization is easy to miss. The bench models the pin as a wired-AND, so the block's drive and a simulated outside pull both reach the sensed input. It then applies an outside pull that starts and ends inside the block's own drive window, and checks that the total reset length and the recorded cause are unchanged. A watchdog pulse injected a thousand cycles into the power-on count shows that the stabilization phase is neither cut short nor extended.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        PH_STAB  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_TAIL  = 2'd2,
        PH_RUN   = 2'd3
    } phase_e;

    localparam int NUM_CAUSE = 6;
    localparam int NUM_REQ   = NUM_CAUSE - 1;

    // status bit positions; request index = status bit - 1, lower index wins
    localparam int CS_POR  = 0;
    localparam int CS_LVD  = 1;
    localparam int CS_WDT  = 2;
    localparam int CS_OP   = 3;
    localparam int CS_ADDR = 4;
    localparam int CS_PIN  = 5;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rstseq_cause_pick.sv
module rstseq_cause_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_prio
        assign pick[i]    = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end
    assign any = taken[N];
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int STAB_CYCLES  = 4096,
    parameter int DRIVE_CYCLES = 32,
    parameter int TAIL_CYCLES  = 32,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 por,
    input  logic                 lvd_req,
    input  logic                 wdt_req,
    input  logic                 bad_op_req,
    input  logic                 bad_addr_req,
    input  logic                 pin_sense_n,
    input  logic                 status_rd,
    output logic                 pin_pull_low,
    output logic                 int_rst,
    output logic                 clk_en,
    output logic                 cpu_run,
    output logic [NUM_CAUSE-1:0] status
);
    localparam int MAX_A   = (STAB_CYCLES > DRIVE_CYCLES) ? STAB_CYCLES : DRIVE_CYCLES;
    localparam int MAX_CYC = (MAX_A > TAIL_CYCLES) ? MAX_A : TAIL_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] STAB_LAST  = CNT_W'(STAB_CYCLES - 1);
    localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYCLES - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST  = CNT_W'(TAIL_CYCLES - 1);

    typedef struct packed {
        phase_e                 phase;
        logic [CNT_W-1:0]       cnt;
        logic [NUM_CAUSE-1:0]   status;
        logic                   drive;
        logic                   rst;
        logic                   gate_en;
        logic                   run;
        logic [SYNC_STAGES-1:0] hist;
    } seq_t;

    seq_t seq_d, seq_q;

    // synchronized inputs, pin idles high
    logic [NUM_REQ-1:0] raw_in, sync_in;
    assign raw_in = {pin_sense_n, bad_addr_req, bad_op_req, wdt_req, lvd_req};

    rstseq_sync #(
        .WIDTH   (NUM_REQ),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, {(NUM_REQ-1){1'b0}}})
    ) i_sync (
        .clk  (clk),
        .arst (por),
        .d    (raw_in),
        .q    (sync_in)
    );

    // pin is only believed when neither our drive nor its synchronizer echo is present
    logic               pin_low_seen;
    logic [NUM_REQ-1:0] req_vec, pick;
    logic               any_req;

    assign pin_low_seen = ~sync_in[CS_PIN-1] & ~seq_q.drive & ~(|seq_q.hist);
    assign req_vec      = {pin_low_seen, sync_in[NUM_REQ-2:0]};

    rstseq_cause_pick #(.N(NUM_REQ)) i_pick (
        .req  (req_vec),
        .pick (pick),
        .any  (any_req)
    );

    always_comb begin
        logic take;
        seq_d = seq_q;

        seq_d.hist[0] = seq_q.drive;
        for (int i = 1; i < SYNC_STAGES; i++) seq_d.hist[i] = seq_q.hist[i-1];

        if (status_rd) seq_d.status = '0;

        take = any_req && (seq_q.phase != PH_STAB);

        if (seq_q.phase == PH_STAB) begin
            if (seq_q.cnt == STAB_LAST) begin
                seq_d.phase = PH_DRIVE;
                seq_d.cnt   = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end else if (take) begin
            seq_d.status = {pick, 1'b0};
            seq_d.phase  = pick[CS_PIN-1] ? PH_TAIL : PH_DRIVE;
            seq_d.cnt    = '0;
        end else begin
            unique case (seq_q.phase)
                PH_DRIVE: begin
                    if (seq_q.cnt == DRIVE_LAST) begin
                        seq_d.phase = PH_TAIL;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (seq_q.cnt == TAIL_LAST) begin
                        seq_d.phase = PH_RUN;
                        seq_d.cnt   = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                default: seq_d.cnt = '0;
            endcase
        end

        seq_d.rst     = (seq_d.phase != PH_RUN);
        seq_d.gate_en = (seq_d.phase != PH_STAB);
        seq_d.drive   = (seq_d.phase == PH_STAB) || (seq_d.phase == PH_DRIVE);
        seq_d.run     = (seq_d.phase == PH_RUN);
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            seq_q         <= '0;
            seq_q.phase   <= PH_STAB;
            seq_q.status  <= NUM_CAUSE'(1) << CS_POR;
            seq_q.drive   <= 1'b1;
            seq_q.rst     <= 1'b1;
            seq_q.gate_en <= 1'b0;
            seq_q.run     <= 1'b0;
            seq_q.hist    <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pin_pull_low = seq_q.drive;
    assign int_rst      = seq_q.rst;
    assign clk_en       = seq_q.gate_en;
    assign cpu_run      = seq_q.run;
    assign status       = seq_q.status;
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk (
    input logic       clk,
    input logic       por,
    input logic       status_rd,
    input logic       pin_pull_low,
    input logic       int_rst,
    input logic       clk_en,
    input logic       cpu_run,
    input logic [5:0] status
);
    // R5: never more than one cause recorded
    a_r5_status_onehot: assert property (@(posedge clk) disable iff (por)
        $onehot0(status));

    // R2: gated clocks only happen inside reset
    a_r2_gate_within_reset: assert property (@(posedge clk) disable iff (por)
        !clk_en |-> int_rst);

    // R3: pin drive only happens inside reset
    a_r3_drive_within_reset: assert property (@(posedge clk) disable iff (por)
        pin_pull_low |-> int_rst);

    // R4: release is clean
    a_r4_release_clean: assert property (@(posedge clk) disable iff (por)
        $fell(int_rst) |-> (clk_en && !pin_pull_low && cpu_run));

    // R4: cpu runs only outside reset
    a_r4_run_excl_reset: assert property (@(posedge clk) disable iff (por)
        cpu_run |-> !int_rst);

    // R12: read clears status unless a new reset starts
    a_r12_read_clears: assert property (@(posedge clk) disable iff (por)
        (status_rd && !int_rst) |=> (int_rst || status == 6'b0));
endmodule

bind reset_sequencer reset_sequencer_chk i_chk (
    .clk          (clk),
    .por          (por),
    .status_rd    (status_rd),
    .pin_pull_low (pin_pull_low),
    .int_rst      (int_rst),
    .clk_en       (clk_en),
    .cpu_run      (cpu_run),
    .status       (status)
);

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic [3:0] req_v = '0;
    logic       ext_low = 1'b0;
    logic       status_rd = 1'b0;
    logic       pin_pull_low, int_rst, clk_en, cpu_run;
    logic [5:0] status;
    logic       pin_sense_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    // wired-AND pin: block pull or outside pull
    assign pin_sense_n = ~(pin_pull_low | ext_low);

    reset_sequencer i_reset_sequencer (
        .clk          (clk),
        .por          (por),
        .lvd_req      (req_v[0]),
        .wdt_req      (req_v[1]),
        .bad_op_req   (req_v[2]),
        .bad_addr_req (req_v[3]),
        .pin_sense_n  (pin_sense_n),
        .status_rd    (status_rd),
        .pin_pull_low (pin_pull_low),
        .int_rst      (int_rst),
        .clk_en       (clk_en),
        .cpu_run      (cpu_run),
        .status       (status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // samples then drives each cycle, at negedge+1
    task automatic measure(input int n, input logic [3:0] m1, input int at1,
                           input logic [3:0] m2, input int at2,
                           input int ext_from, input int ext_to,
                           output int c_rst, output int c_drv, output int c_gate);
        c_rst = 0; c_drv = 0; c_gate = 0;
        for (int i = 0; i < n; i++) begin
            c_rst  += int'(int_rst);
            c_drv  += int'(pin_pull_low);
            c_gate += int'(!clk_en);
            req_v = '0;
            if (i == at1) req_v = req_v | m1;
            if (i == at2) req_v = req_v | m2;
            ext_low = (i >= ext_from) && (i < ext_to);
            @(negedge clk); #1;
        end
        req_v = '0;
        ext_low = 1'b0;
    endtask

    task automatic t_power_on(input logic [3:0] inject);
        int r, d, g;
        @(negedge clk); #1;
        chk("R1", int'({int_rst, clk_en, pin_pull_low, cpu_run}), 4'b1010);
        chk("R1", int'(status), 1);
        por = 1'b0;
        measure(4400, inject, 1000, 4'b0, -1, -1, -1, r, d, g);
        chk("R2", g, 4096);
        chk(inject != 0 ? "R11" : "R3", d, 4128);
        chk("R4", r, 4160);
        chk("R4", int'(cpu_run), 1);
        chk(inject != 0 ? "R11" : "R5", int'(status), 1);
    endtask

    task automatic t_internal(input int idx);
        int r, d, g;
        measure(120, 4'(1 << idx), 0, 4'b0, -1, -1, -1, r, d, g);
        chk("R6", d, 32);
        chk("R6", r, 64);
        chk("R6", g, 0);
        chk("R5", int'(status), 1 << (idx + 1));
    endtask

    task automatic t_external();
        int r, d, g;
        measure(120, 4'b0, -1, 4'b0, -1, 0, 5, r, d, g);
        chk("R7", r, 5 + 31);
        chk("R7", d, 0);
        chk("R5", int'(status), 6'b100000);
    endtask

    task automatic t_mask();
        int r, d, g;
        measure(150, 4'b0010, 0, 4'b0, -1, 5, 20, r, d, g);
        chk("R8", r, 64);
        chk("R8", d, 32);
        chk("R8", int'(status), 6'b000100);
    endtask

    task automatic t_restart();
        int r, d, g;
        measure(200, 4'b0001, 0, 4'b0100, 40, -1, -1, r, d, g);
        chk("R9", r, 40 + 64);
        chk("R9", d, 64);
        chk("R9", int'(status), 6'b001000);
    endtask

    task automatic t_priority();
        int r, d, g;
        measure(120, 4'b0011, 0, 4'b0, -1, -1, -1, r, d, g);
        chk("R10", int'(status), 6'b000010);
        chk("R10", r, 64);
        measure(120, 4'b1000, 0, 4'b0, -1, 0, 3, r, d, g);
        chk("R10", int'(status), 6'b010000);
        chk("R10", d, 32);
        chk("R10", r, 64);
    endtask

    task automatic t_read_clear();
        chk("R12", int'(status != 0), 1);
        status_rd = 1'b1;
        @(negedge clk); #1;
        status_rd = 1'b0;
        chk("R12", int'(status), 0);
        chk("R12", int'(int_rst), 0);
    endtask

    task automatic t_por_async();
        por = 1'b1;
        #1;
        chk("R1", int'({int_rst, clk_en, pin_pull_low, cpu_run}), 4'b1010);
        chk("R1", int'(status), 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_power_on(4'b0);
        for (int k = 0; k < 4; k++) t_internal(k);
        t_external();
        t_mask();
        t_restart();
        t_priority();
        t_read_clear();
        t_por_async();
        t_power_on(4'b0010);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule